// File: doc/BRIEF.md
# Command-framed SPI register master

This block drives single-register transactions toward a remote SPI slave over four wires: an active-low select, a serial clock, a master-out data line and a master-in data line. A host hands it one request at a time through a valid/ready handshake. Each request holds a direction flag, a register address and, for a store, a data byte. The block lowers select and shifts out a command byte, which is the flag followed by the address. It then either shifts the data byte out or clocks eight more times to collect a byte from the slave. It raises select again and pulses `done`.

Every frame has a fixed length of command width plus data width clock pulses, which is sixteen with the default parameters. The serial clock is made from the system clock with a parameterised divider. Data leaves most significant bit first. The line changes on a falling edge and is held while the clock is high, so the slave can capture it on the rising edge. Returned data is sampled on falling edges. After each frame, select stays high for at least one full serial clock period before the next request is taken.

Top module: `regframe_spi_master`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `spi_cs_n`=1, `spi_sclk`=0, `spi_mosi`=1, `req_ready`=1, `done`=0 and `rsp_rdata`=0.
- R2: A request is taken at an edge where `req_valid` and `req_ready` are both 1. `spi_cs_n` goes low and `req_ready` goes low after that edge. Request inputs that change while the block is busy have no effect on the frame in flight.
- R3: Each frame has exactly 1+ADDR_W+DATA_W rising edges of `spi_sclk` (16 by default), and `spi_sclk` is 0 whenever `spi_cs_n` is 1.
- R4: The first CMD_W bits shifted out carry the command. The first bit is the direction (1 = write, 0 = read), followed by `req_addr` most significant bit first.
- R5: In a write frame, the last DATA_W bits on `spi_mosi` are `req_wdata`, most significant bit first.
- R6: In a read frame, `spi_mosi` is 0 during the data bits and `spi_miso` is sampled at each falling edge of `spi_sclk`. The first sampled bit becomes bit DATA_W-1 of `rsp_rdata`, which updates in the cycle `done` is high.
- R7: Every high and low phase of `spi_sclk` lasts HALF_DIV system clocks. The first rising edge comes HALF_DIV clocks after `spi_cs_n` falls, and `spi_cs_n` rises HALF_DIV clocks after the last falling edge.
- R8: `done` is high for exactly one cycle, the first cycle with `spi_cs_n` high after a frame. `rsp_rdata` changes only at the end of a read frame.
- R9: After a frame, `spi_cs_n` stays high with `req_ready`=0 for 2*HALF_DIV cycles. `spi_mosi` is 1 while select is high.
- R10: `spi_mosi` stays stable while `spi_sclk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = store to slave, 0 = fetch from slave |
| req_addr | input | ADDR_W | Remote register address |
| req_wdata | input | DATA_W | Byte to store |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rsp_rdata | output | DATA_W | Byte fetched by the last read |
| spi_cs_n | output | 1 | Slave select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data toward the slave |
| spi_miso | input | 1 | Serial data from the slave |

## Verification
All results are timed from the acceptance edge E. Select falls right after E. Rising edge k comes at E+HALF_DIV*(1+2k) and falling edge k at E+HALF_DIV*(2+2k). Select rises, `done` pulses and the fetched byte appears at E+HALF_DIV*(2*FRAME_W+1), and `req_ready` returns 2*HALF_DIV clocks after that. The bench keeps its own cycle counter from each acceptance, derives every expected output from these formulas, and compares them on the falling system clock edge after each rising edge. The modelled slave puts each return bit on `spi_miso` only during the high phase before the matching falling edge and drives toggling filler at all other times, so a sample taken one cycle early or late gives the wrong byte.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_HIGH,
      ST_LOW,
      ST_HOLD,
      ST_GAP
   } rfs_state_t;

   function automatic int unsigned rfs_bits(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v);
   endfunction

endpackage

// File: rtl/rfs_phase_timer.sv
module rfs_phase_timer #(
   parameter int unsigned HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic gap_sel,
   output logic expire
);
   localparam int unsigned GAP_CYC = 2 * HALF_DIV;
   localparam int unsigned CW      = rfs_pkg::rfs_bits(GAP_CYC);

   generate
      if (HALF_DIV == 1) begin : g_unit
         logic second_q;
         assign expire = run && (!gap_sel || second_q);
         always_ff @(posedge clk) begin
            if (!rst_n) second_q <= 1'b0;
            else        second_q <= run && gap_sel && !second_q;
         end
      end else begin : g_count
         localparam logic [CW-1:0] HALF_LIM = CW'(HALF_DIV - 1);
         localparam logic [CW-1:0] GAP_LIM  = CW'(GAP_CYC - 1);
         logic [CW-1:0] cnt_q;
         logic [CW-1:0] limit;
         assign limit  = gap_sel ? GAP_LIM : HALF_LIM;
         assign expire = run && (cnt_q == limit);
         always_ff @(posedge clk) begin
            if (!rst_n || !run || expire) cnt_q <= '0;
            else                          cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/rfs_shift_unit.sv
module rfs_shift_unit #(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              is_write,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] wdata_in,
   input  logic              advance,
   input  logic              capture,
   input  logic              finish,
   input  logic              read_txn,
   input  logic              miso,
   output logic              mosi,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned FRAME_W = 1 + ADDR_W + DATA_W;

   logic [FRAME_W-1:0] tx_q;
   logic [DATA_W-1:0]  rx_q;
   logic [DATA_W-1:0]  rdata_q;
   logic [DATA_W-1:0]  data_field;

   // read frames send a zero data field
   assign data_field = is_write ? wdata_in : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)       tx_q <= '1;
      else if (load)    tx_q <= {is_write, addr_in, data_field};
      else if (finish)  tx_q <= '1;
      else if (advance) tx_q <= {tx_q[FRAME_W-2:0], 1'b1};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       rx_q <= '0;
      else if (capture) rx_q <= {rx_q[DATA_W-2:0], miso};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                 rdata_q <= '0;
      else if (finish && read_txn) rdata_q <= rx_q;
   end

   assign mosi  = tx_q[FRAME_W-1];
   assign rdata = rdata_q;
endmodule

// File: rtl/rfs_sequencer.sv
module rfs_sequencer #(
   parameter int unsigned CMD_W   = 8,
   parameter int unsigned FRAME_W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_write,
   input  logic expire,
   output logic req_ready,
   output logic run,
   output logic gap_sel,
   output logic load,
   output logic advance,
   output logic capture,
   output logic finish,
   output logic read_txn,
   output logic cs_n,
   output logic sclk,
   output logic done
);
   import rfs_pkg::*;

   localparam int unsigned BW = rfs_bits(FRAME_W + 1);
   localparam logic [BW-1:0] LAST_BIT  = BW'(FRAME_W - 1);
   localparam logic [BW-1:0] FIRST_DAT = BW'(CMD_W);

   rfs_state_t    state_q;
   logic [BW-1:0] bit_q;
   logic          write_q;
   logic          cs_n_q;
   logic          sclk_q;
   logic          done_q;
   logic          accept;

   assign accept    = req_valid && (state_q == ST_IDLE);
   assign req_ready = (state_q == ST_IDLE);
   assign run       = (state_q != ST_IDLE);
   assign gap_sel   = (state_q == ST_GAP);
   assign load      = accept;
   assign advance   = (state_q == ST_HIGH) && expire;
   assign capture   = advance && !write_q && (bit_q >= FIRST_DAT);
   assign finish    = (state_q == ST_HOLD) && expire;
   assign read_txn  = !write_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bit_q   <= '0;
         write_q <= 1'b0;
         cs_n_q  <= 1'b1;
         sclk_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q <= ST_SETUP;
                  bit_q   <= '0;
                  write_q <= req_write;
                  cs_n_q  <= 1'b0;
               end
            end
            ST_SETUP: begin
               if (expire) begin
                  state_q <= ST_HIGH;
                  sclk_q  <= 1'b1;
               end
            end
            ST_HIGH: begin
               if (expire) begin
                  sclk_q <= 1'b0;
                  if (bit_q == LAST_BIT) begin
                     state_q <= ST_HOLD;
                  end else begin
                     state_q <= ST_LOW;
                     bit_q   <= bit_q + 1'b1;
                  end
               end
            end
            ST_LOW: begin
               if (expire) begin
                  state_q <= ST_HIGH;
                  sclk_q  <= 1'b1;
               end
            end
            ST_HOLD: begin
               if (expire) begin
                  state_q <= ST_GAP;
                  cs_n_q  <= 1'b1;
                  done_q  <= 1'b1;
               end
            end
            ST_GAP: begin
               if (expire) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cs_n = cs_n_q;
   assign sclk = sclk_q;
   assign done = done_q;
endmodule

// File: rtl/regframe_spi_master.sv
module regframe_spi_master #(
   parameter int unsigned ADDR_W   = 7,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned HALF_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              spi_cs_n,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso
);
   localparam int unsigned CMD_W   = 1 + ADDR_W;
   localparam int unsigned FRAME_W = CMD_W + DATA_W;

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be at least 1");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
   endgenerate

   logic run, gap_sel, expire;
   logic load, advance, capture, finish, read_txn;

   rfs_phase_timer #(.HALF_DIV(HALF_DIV)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .gap_sel (gap_sel),
      .expire  (expire)
   );

   rfs_sequencer #(.CMD_W(CMD_W), .FRAME_W(FRAME_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .expire    (expire),
      .req_ready (req_ready),
      .run       (run),
      .gap_sel   (gap_sel),
      .load      (load),
      .advance   (advance),
      .capture   (capture),
      .finish    (finish),
      .read_txn  (read_txn),
      .cs_n      (spi_cs_n),
      .sclk      (spi_sclk),
      .done      (done)
   );

   rfs_shift_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .is_write (req_write),
      .addr_in  (req_addr),
      .wdata_in (req_wdata),
      .advance  (advance),
      .capture  (capture),
      .finish   (finish),
      .read_txn (read_txn),
      .miso     (spi_miso),
      .mosi     (spi_mosi),
      .rdata    (rsp_rdata)
   );
endmodule

// File: rtl/rfs_checker.sv
module rfs_checker #(
   parameter int unsigned ADDR_W   = 7,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned HALF_DIV = 4
) (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic done,
   input logic spi_cs_n,
   input logic spi_sclk,
   input logic spi_mosi
);
   localparam int unsigned FRAME_W = 1 + ADDR_W + DATA_W;
   localparam int unsigned SAT     = 2 * HALF_DIV + 2;

   logic       sclk_d, cs_d;
   int unsigned rise_cnt, run_len, hi_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_d   <= 1'b0;
         cs_d     <= 1'b1;
         rise_cnt <= 0;
         run_len  <= 0;
         hi_len   <= SAT;
      end else begin
         sclk_d <= spi_sclk;
         cs_d   <= spi_cs_n;
         if (cs_d && !spi_cs_n)          rise_cnt <= 0;
         else if (spi_sclk && !sclk_d)   rise_cnt <= rise_cnt + 1;
         if ((cs_d && !spi_cs_n) || (spi_sclk != sclk_d)) run_len <= 1;
         else if (run_len < SAT)         run_len <= run_len + 1;
         if (!spi_cs_n)                  hi_len <= 0;
         else if (hi_len < SAT)          hi_len <= hi_len + 1;
      end
   end

   AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk); // R3
   AST_FRAME_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |-> (rise_cnt == FRAME_W)); // R3
   AST_ACCEPT_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!spi_cs_n && !req_ready)); // R2
   AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (spi_cs_n && spi_mosi && !spi_sclk)); // R9
   AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $rose(spi_cs_n)); // R8
   AST_RELEASE_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |-> done); // R8
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi)); // R10
   AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(spi_sclk) || $fell(spi_sclk)) |-> (run_len == HALF_DIV)); // R7
   AST_RELEASE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |-> (run_len == HALF_DIV)); // R7
   AST_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> (hi_len >= 2 * HALF_DIV)); // R9
endmodule

bind regframe_spi_master rfs_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HALF_DIV(HALF_DIV)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .done      (done),
   .spi_cs_n  (spi_cs_n),
   .spi_sclk  (spi_sclk),
   .spi_mosi  (spi_mosi)
);

// File: tb/regframe_spi_master_tb.sv
`timescale 1ns/1ps
module regframe_spi_master_tb;
   localparam int AW = 7;
   localparam int DW = 8;
   localparam int H  = 4;
   localparam int FR = 1 + AW + DW;
   localparam int CW = 1 + AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic spi_miso = 1'b0;
   logic req_ready, done, spi_cs_n, spi_sclk, spi_mosi;
   logic [DW-1:0] rsp_rdata;
   logic [DW-1:0] drv_sbyte = '0;

   always #5 clk = ~clk;

   regframe_spi_master #(.ADDR_W(AW), .DATA_W(DW), .HALF_DIV(H)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .done(done), .rsp_rdata(rsp_rdata), .spi_cs_n(spi_cs_n),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

   int checks = 0, fails = 0, cycles = 0;
   bit started = 0;

   // reference model state
   int n = -1;
   logic [FR-1:0] m_frame;
   logic          m_write;
   logic [DW-1:0] m_sbyte;
   logic [DW-1:0] m_rdata = '0;
   logic [FR-1:0] pending_q[$];

   task automatic chk(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h at cycle %0d", tag, what, act, exp, cycles);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         n = -1;
         m_rdata = '0;
      end else if (n < 0) begin
         if (req_valid) begin
            n = 0;
            m_write = req_write;
            m_frame = {req_write, req_addr, req_write ? req_wdata : {DW{1'b0}}};
            m_sbyte = drv_sbyte;
            pending_q.push_back(m_frame);
         end
      end else begin
         n = n + 1;
         if (n == 33 * H && !m_write) m_rdata = m_sbyte;
         if (n == 35 * H) n = -1;
      end
   end

   logic prev_sclk_exp = 1'b0;
   logic prev_mosi = 1'b1;

   always @(negedge clk) begin
      logic e_cs, e_sclk, e_mosi, e_done, e_ready;
      int   k;
      cycles++;
      if (started) begin
         e_cs    = !(n >= 0 && n < 33 * H);
         e_sclk  = (n >= H && n < 33 * H) && (((n - H) % (2 * H)) < H);
         e_mosi  = (n >= 0 && n < 32 * H) ? m_frame[FR - 1 - n / (2 * H)] : 1'b1;
         e_done  = (n == 33 * H);
         e_ready = (n < 0);
         k       = (n >= 0) ? n / (2 * H) : 0;
         chk("R7", "spi_cs_n", DW'(spi_cs_n), DW'(e_cs));
         chk("R3", "spi_sclk", DW'(spi_sclk), DW'(e_sclk));
         if (n < 0 || n >= 32 * H) chk("R9", "idle spi_mosi", DW'(spi_mosi), DW'(e_mosi));
         else if (k < CW)          chk("R4", "command bit", DW'(spi_mosi), DW'(e_mosi));
         else if (m_write)         chk("R5", "write data bit", DW'(spi_mosi), DW'(e_mosi));
         else                      chk("R6", "read fill bit", DW'(spi_mosi), DW'(e_mosi));
         if (e_sclk && prev_sclk_exp) chk("R10", "mosi while high", DW'(spi_mosi), DW'(prev_mosi));
         chk("R8", "done", DW'(done), DW'(e_done));
         chk((n >= 33 * H) ? "R9" : "R2", "req_ready", DW'(req_ready), DW'(e_ready));
         chk("R6", "rsp_rdata", rsp_rdata, m_rdata);
         prev_sclk_exp = e_sclk;
         prev_mosi     = spi_mosi;
         // modelled slave: valid bit only in the high phase before its falling edge
         if (e_sclk && k >= CW && !m_write) spi_miso = m_sbyte[FR - 1 - k];
         else                               spi_miso = cycles[0];
      end
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   always @(posedge clk) started <= 1'b1;

   task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [DW-1:0] sb);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; drv_sbyte = sb;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      req_write = ~wr; req_addr = ~a; req_wdata = ~d;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset values
      chk("R1", "cs_n in reset", DW'(spi_cs_n), 8'd1);
      chk("R1", "sclk in reset", DW'(spi_sclk), 8'd0);
      chk("R1", "mosi in reset", DW'(spi_mosi), 8'd1);
      chk("R1", "ready in reset", DW'(req_ready), 8'd1);
      chk("R1", "done in reset", DW'(done), 8'd0);
      rst_n = 1'b1;
      @(negedge clk);
      issue(1'b1, 7'h01, 8'h04, 8'h00);       // store 0x04 at address 1
      wait_idle();
      issue(1'b0, 7'h01, 8'h00, 8'hA5);       // fetch address 1
      wait_idle();
      chk("R6", "read byte after frame", rsp_rdata, 8'hA5);
      issue(1'b0, 7'h7F, 8'hFF, 8'h3C);       // top address, wdata ignored on read
      wait_idle();
      issue(1'b1, 7'h55, 8'hFF, 8'h99);       // write leaves rsp_rdata (R8)
      wait_idle();
      chk("R8", "rdata kept after write", rsp_rdata, 8'h3C);
      issue(1'b1, 7'h00, 8'h00, 8'h00);
      // back-to-back: second request waits through the gap (R9, R2)
      issue(1'b0, 7'h2A, 8'h00, 8'h81);
      issue(1'b0, 7'h15, 8'h00, 8'h7E);
      wait_idle();
      chk("R6", "second back-to-back read", rsp_rdata, 8'h7E);
      // reset in the middle of a frame
      issue(1'b1, 7'h33, 8'hC3, 8'h00);
      repeat (50) @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1", "cs_n after mid-frame reset", DW'(spi_cs_n), 8'd1);
      chk("R1", "rdata after mid-frame reset", rsp_rdata, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      issue(1'b0, 7'h40, 8'h00, 8'h5A);
      wait_idle();
      chk("R2", "frames accepted", DW'(pending_q.size()), 8'd9);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule